// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small multicycle processor built around one accumulator register. Every instruction word carries an opcode in its upper bits and a direct memory address in its lower bits. Execution walks through an explicit register-transfer sequence. The instruction pointer is copied into the memory address register, and memory is read into the memory data register. The instruction register is loaded from the data register, and the opcode is then decoded. Every operand access goes through the same address and data registers.

The core drives one synchronous single-port memory that sits outside it. The memory registers its read data on the clock edge that ends a read strobe. The core captures that data one cycle later. The instruction pointer advances in the same cycle as the instruction read. Three operations exist: load the accumulator, add to it, and store it. A stop opcode, or any opcode the core does not define, ends execution and raises a halted flag.

Top module: `acc_core`

## Requirements
- R1: While reset is high on a clock edge, the core clears its registers: after that edge `acc`, `halted`, `mem_re`, `mem_we` and `mem_addr` all read zero. Once reset is released, execution starts at word 0.
- R2: An instruction word has the opcode in bits [7:5] and the address in bits [4:0]. The opcodes are 3'b001 load, 3'b010 add, 3'b011 store and 3'b111 stop; every other opcode is undefined.
- R3: Each instruction is fetched with exactly one read strobe. Fetch addresses start at 0 and rise by one per executed instruction (modulo 32). Stores may overwrite words that have not yet been fetched, and the fetch returns the new value.
- R4: A load issues one read at the instruction's address field, and the accumulator then holds the word returned.
- R5: An add issues one read at the address field and adds the returned word to the accumulator, modulo 256.
- R6: A store issues exactly one write strobe, at the address field, carrying the accumulator value. The accumulator is unchanged.
- R7: A stop or undefined opcode raises `halted`. It stays high until reset, and no read or write strobe occurs while it is high.
- R8: At most one strobe is active per cycle. A load or an add takes 8 cycles, a store takes 7, and a stop word raises `halted` on the 5th clock edge after its fetch sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 5 | Memory address (memory address register) |
| mem_re | output | 1 | Read strobe; memory data is valid on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data (memory data register) |
| mem_rdata | input | 8 | Registered read data from memory |
| acc | output | 8 | Accumulator |
| halted | output | 1 | Execution stopped; held until reset |

## Verification
The bench builds the core with its default address width of 5, so a word is 8 bits and memory holds 32 words. With that width, small operand values drive additions past 255, which exercises the modulo-256 wrap. The same width lets programs store into their own instruction words, so a later fetch returns the rewritten word. Each program is sized so that its cycle total follows from its counts of loads, adds and stores, and that total is compared exactly.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_LOAD  = 3'b001;
  localparam logic [OP_W-1:0] OPC_ADD   = 3'b010;
  localparam logic [OP_W-1:0] OPC_STORE = 3'b011;
  localparam logic [OP_W-1:0] OPC_STOP  = 3'b111;

  typedef enum logic [3:0] {
    ST_F_MAR,
    ST_F_RD,
    ST_F_CAP,
    ST_F_IR,
    ST_DEC,
    ST_O_RD,
    ST_O_CAP,
    ST_O_EXE,
    ST_S_MDR,
    ST_S_WR,
    ST_STOP
  } state_e;

  // Micro-operation strobes for the datapath
  typedef struct packed {
    logic mar_ip;
    logic mar_ir;
    logic ip_inc;
    logic mdr_mem;
    logic mdr_acc;
    logic ir_mdr;
    logic acc_ld;
    logic acc_add;
  } uop_t;

  typedef struct packed {
    logic load;
    logic add;
    logic store;
    logic stop;
  } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);

  always_comb begin
    dec = '0;
    unique case (op)
      OPC_LOAD:  dec.load  = 1'b1;
      OPC_ADD:   dec.add   = 1'b1;
      OPC_STORE: dec.store = 1'b1;
      default:   dec.stop  = 1'b1;  // stop and all undefined codes (R7)
    endcase
  end

  // R2: exactly one class per opcode
  always_comb begin
    a_one_class_r2: assert ($countones(dec) == 1);
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  dec_t dec,
  output uop_t uop,
  output logic mem_re,
  output logic mem_we,
  output logic halted
);

  state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_F_MAR: nxt = ST_F_RD;
      ST_F_RD:  nxt = ST_F_CAP;
      ST_F_CAP: nxt = ST_F_IR;
      ST_F_IR:  nxt = ST_DEC;
      ST_DEC: begin
        if (dec.stop)       nxt = ST_STOP;
        else if (dec.store) nxt = ST_S_MDR;
        else                nxt = ST_O_RD;
      end
      ST_O_RD:  nxt = ST_O_CAP;
      ST_O_CAP: nxt = ST_O_EXE;
      ST_O_EXE: nxt = ST_F_MAR;
      ST_S_MDR: nxt = ST_S_WR;
      ST_S_WR:  nxt = ST_F_MAR;
      ST_STOP:  nxt = ST_STOP;
      default:  nxt = ST_F_MAR;
    endcase
  end

  always_comb begin
    uop = '0;
    unique case (state)
      ST_F_MAR: uop.mar_ip  = 1'b1;
      ST_F_RD:  uop.ip_inc  = 1'b1;
      ST_F_CAP: uop.mdr_mem = 1'b1;
      ST_F_IR:  uop.ir_mdr  = 1'b1;
      ST_DEC:   uop.mar_ir  = !dec.stop;
      ST_O_CAP: uop.mdr_mem = 1'b1;
      ST_O_EXE: begin
        uop.acc_ld  = dec.load;
        uop.acc_add = dec.add;
      end
      ST_S_MDR: uop.mdr_acc = 1'b1;
      default:  uop = '0;
    endcase
  end

  // Strobes are registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_F_MAR;
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      halted <= 1'b0;
    end else begin
      state  <= nxt;
      mem_re <= (nxt == ST_F_RD) || (nxt == ST_O_RD);
      mem_we <= (nxt == ST_S_WR);
      if (nxt == ST_STOP) halted <= 1'b1;
    end
  end

  p_halt_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(state) == ST_DEC);

  p_strobe_state_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> state == ST_S_WR);

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = OP_W + ADDR_W
)(
  input  logic              clk,
  input  logic              rst,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OP_W-1:0]   ir_op,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc
);

  logic [ADDR_W-1:0] ip;
  logic [DATA_W-1:0] ir;

  assign ir_op = ir[DATA_W-1 -: OP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ip  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (uop.mar_ip)      mar <= ip;
      else if (uop.mar_ir) mar <= ir[ADDR_W-1:0];
      if (uop.ip_inc)      ip  <= ip + 1'b1;
      if (uop.mdr_mem)      mdr <= mem_rdata;
      else if (uop.mdr_acc) mdr <= acc;
      if (uop.ir_mdr)      ir  <= mdr;
      if (uop.acc_ld)       acc <= mdr;
      else if (uop.acc_add) acc <= acc + mdr;  // wraps modulo 2^DATA_W (R5)
    end
  end

  p_ip_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !uop.ip_inc |=> $stable(ip));

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (uop.mdr_acc || uop.mar_ip) |=> $stable(acc));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter  int ADDR_W = 5,
  localparam int DATA_W = OP_W + ADDR_W
)(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic              halted
);

  uop_t            uop;
  dec_t            dec;
  logic [OP_W-1:0] ir_op;

  acc_decode i_decode (
    .op  (ir_op),
    .dec (dec)
  );

  acc_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .dec    (dec),
    .uop    (uop),
    .mem_re (mem_re),
    .mem_we (mem_we),
    .halted (halted)
  );

  acc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .ir_op     (ir_op),
    .mar       (mem_addr),
    .mdr       (mem_wdata),
    .acc       (acc)
  );

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_quiet_halted_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_re && !mem_we));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  p_store_data_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == acc);

endmodule

// File: tb/test_acc_core.sv
module test_acc_core;

  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] acc;
  logic          halted;

  always #2 clk = ~clk;  // 250 MHz

  acc_core #(.ADDR_W(AW)) i_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc(acc), .halted(halted)
  );

  int errors = 0;
  int checks = 0;

  // Memory model; image reloaded during reset
  logic [DW-1:0] img [NW];
  logic [DW-1:0] mem [NW];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= img[i];
      mem_rdata <= '0;
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } item_t;
  item_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compare every bus strobe with the next expected item
  always @(negedge clk) begin
    if (!rst && (mem_re || mem_we)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected access at addr", int'(mem_addr), -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(mem_we == it.wr, it.req, "access kind (1=write)", int'(mem_we), int'(it.wr));
        check(mem_addr == it.addr, it.req, "access address", int'(mem_addr), int'(it.addr));
        if (it.wr)
          check(mem_wdata == it.data, it.req, "write data", int'(mem_wdata), int'(it.data));
      end
    end
  end

  function automatic logic [DW-1:0] enc(input logic [2:0] op, input int a);
    return {op, a[AW-1:0]};  // R2: opcode in [7:5], address in [4:0]
  endfunction

  // Driver: ISA-level model pushes expected bus items, then runs the core
  task automatic run_test(input string name);
    logic [DW-1:0] m [NW];
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] a  = '0;
    int nl = 0, ns = 0, exp_cyc, halt_cyc = -1;
    bit stop = 0;
    exp_q.delete();
    for (int i = 0; i < NW; i++) m[i] = img[i];
    for (int s = 0; s < 64 && !stop; s++) begin
      logic [DW-1:0] w;
      logic [AW-1:0] ad;
      w  = m[pc];
      ad = w[AW-1:0];
      exp_q.push_back('{0, pc, '0, "R3"});
      pc = pc + 1'b1;
      case (w[DW-1 -: 3])
        3'b001: begin exp_q.push_back('{0, ad, '0, "R4"}); a = m[ad]; nl++; end
        3'b010: begin exp_q.push_back('{0, ad, '0, "R5"}); a = a + m[ad]; nl++; end
        3'b011: begin exp_q.push_back('{1, ad, a, "R6"}); m[ad] = a; ns++; end
        default: stop = 1;
      endcase
    end
    exp_cyc = 8 * nl + 7 * ns + 5;

    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(acc == 0 && halted == 0 && mem_re == 0 && mem_we == 0 && mem_addr == 0,
          "R1", {name, " reset state"}, int'({acc, halted, mem_re, mem_we}), 0);
    rst = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (halted) begin halt_cyc = cyc; break; end
    end
    check(halt_cyc == exp_cyc, "R8", {name, " cycles to halt"}, halt_cyc, exp_cyc);
    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R7", {name, " halted held"}, int'(halted), 1);
    check(exp_q.size() == 0, "R3", {name, " expected accesses left"}, exp_q.size(), 0);
    check(acc == a, "R5", {name, " final accumulator"}, int'(acc), int'(a));
    for (int i = 0; i < NW; i++)
      check(mem[i] == m[i], "R6", {name, " memory word"}, int'(mem[i]), int'(m[i]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // T1: load, add with wrap, stores (R4 R5 R6)
    for (int i = 0; i < NW; i++) img[i] = '0;
    img[0] = enc(3'b001, 20); img[1] = enc(3'b010, 21); img[2] = enc(3'b011, 22);
    img[3] = enc(3'b010, 21); img[4] = enc(3'b011, 23); img[5] = enc(3'b111, 0);
    img[20] = 8'd200; img[21] = 8'd100;
    run_test("t1");
    // T2: undefined opcode stops; a store after it must not happen (R7)
    for (int i = 0; i < NW; i++) img[i] = '0;
    img[0] = enc(3'b001, 25); img[1] = enc(3'b011, 26); img[2] = enc(3'b101, 0);
    img[3] = enc(3'b011, 27); img[25] = 8'h5A;
    run_test("t2");
    // T3: zero word at address 0 is undefined, halts at once (R7 R8)
    for (int i = 0; i < NW; i++) img[i] = '0;
    run_test("t3");
    // T4: store rewrites a later instruction into stop (R3)
    for (int i = 0; i < NW; i++) img[i] = '0;
    img[0] = enc(3'b001, 30); img[1] = enc(3'b011, 3); img[2] = enc(3'b010, 31);
    img[3] = enc(3'b011, 29); img[30] = enc(3'b111, 0); img[31] = 8'd1;
    run_test("t4");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule